// File: doc/BRIEF.md
# Fixed-Priority Bus Ownership Arbiter

This block decides which of up to sixteen bus masters owns a shared pipelined bus. Each master raises a request line and, when it needs an unbroken sequence, a lock line. The arbiter also watches the transfer type, burst type and response on the bus, and the ready line that ends each transfer. It drives a one-hot grant vector, the index of the master that owns the address phase, and the index of the master whose data phase is in progress. That second index is what a write-data multiplexer uses. A flag shows when the current owner holds the bus as a locked sequence.

All decisions are taken at a rising clock edge where ready is high, and every output comes from a register. The lowest-numbered eligible requester wins. Ownership is held for the full length of a fixed-length burst and for as long as the owner keeps its lock line high. A master that receives a split response leaves arbitration until its bit on the split-release input is seen. When nobody is eligible, master 0 is granted as the default owner.

Top module: `mst_arbiter`

## Requirements
- R1: While the synchronous active-high reset is applied, owner and data-phase owner are 0, grant is 1 (bit 0 only) and the lock flag is low.
- R2: At a rising edge with ready high, and with no hold in force, owner becomes the lowest index among masters that request and are not split-masked. If there is no such master, owner becomes 0.
- R3: Grant is always one-hot, with its single set bit at the position given by owner.
- R4: At an edge with ready low, owner, grant, data-phase owner and the lock flag keep their values.
- R5: At every edge with ready high, the data-phase owner takes the owner value that held before that edge.
- R6: A NONSEQ transfer (transfer code 10) with a burst code of 010 or 011 (4 beats), 100 or 101 (8 beats), or 110 or 111 (16 beats) holds ownership. A SEQ transfer (code 11) at a ready edge counts one beat. Re-arbitration happens at the edge that accepts the last beat. BUSY (code 01) counts nothing and keeps the hold.
- R7: A burst code of 000 (single) or 001 (unspecified length) sets no hold. An IDLE transfer (code 00) at a ready edge ends any fixed-burst hold at once.
- R8: While the owner's lock line is high, ownership does not change. At each ready edge the lock flag takes the lock line of the master chosen as owner at that edge.
- R9: A SPLIT response (code 11) at a ready edge masks the data-phase owner. A masked master is never chosen through arbitration while the mask is set, even if it requests.
- R10: A set split-release bit clears that master's mask at the edge. Arbitration first sees the cleared mask at the following edge. If the mask is set and released for the same master in the same cycle, the set wins.
- R11: A RETRY response (code 10) at a ready edge cancels any fixed-burst hold and changes no priority, so a retried master that is still the highest-priority requester keeps the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_MST | Per-master bus request |
| lock_req | input | NUM_MST | Per-master locked-sequence request |
| trans | input | 2 | Transfer type of the current address phase |
| burst | input | 3 | Burst type of the current address phase |
| resp | input | 2 | Slave response of the current data phase |
| ready | input | 1 | High when the current transfer completes |
| split_rel | input | NUM_MST | Per-master release of a split mask |
| grant | output | NUM_MST | One-hot grant vector |
| owner | output | IDX_W | Address-phase owner index |
| data_owner | output | IDX_W | Data-phase owner index |
| mst_locked | output | 1 | Current owner holds a locked sequence |

## Verification
The bench runs with four masters and first sweeps every request pattern, checking lowest-index priority and the default to master 0. A design that scanned from the wrong end, or left grant idle with no requester, fails here. It then drives every burst code through complete bursts and counts beats arithmetically. An off-by-one beat counter switches one beat early or late, and a design that treats BUSY as a beat lets go too soon. Focused sequences cover IDLE ending a burst, RETRY in mid-burst, ready held low, a locked hold, and a split mask followed by a release. Those last two catch a mask that never clears, a release that acts one edge early, and a data-phase index that does not lag by one transfer.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_t;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR   = 3'b001,
    BU_WRAP4  = 3'b010,
    BU_INCR4  = 3'b011,
    BU_WRAP8  = 3'b100,
    BU_INCR8  = 3'b101,
    BU_WRAP16 = 3'b110,
    BU_INCR16 = 3'b111
  } burst_t;

  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERROR = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } resp_t;

  localparam int MAX_BEATS = 16;

  // Number of beats of a fixed-length burst, 0 when the length is open.
  function automatic logic [4:0] burst_beats(input logic [2:0] b);
    case (burst_t'(b))
      BU_WRAP4,  BU_INCR4:  burst_beats = 5'd4;
      BU_WRAP8,  BU_INCR8:  burst_beats = 5'd8;
      BU_WRAP16, BU_INCR16: burst_beats = 5'd16;
      default:              burst_beats = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/arb_burst_track.sv
module arb_burst_track
  import arb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic [1:0]       trans,
  input  logic [2:0]       burst,
  input  logic [1:0]       resp,
  output logic [CNT_W-1:0] left_q,
  output logic             hold_nxt
);

  logic [CNT_W-1:0] left_d;
  logic [4:0]       beats;

  always_comb begin
    left_d = left_q;
    beats  = burst_beats(burst);
    if (ready) begin
      if (resp == RS_SPLIT || resp == RS_RETRY) begin
        left_d = '0;
      end else begin
        case (trans_t'(trans))
          TR_IDLE:   left_d = '0;
          TR_BUSY:   left_d = left_q;
          TR_NONSEQ: left_d = (beats == 5'd0) ? '0 : CNT_W'(beats - 5'd1);
          TR_SEQ:    if (left_q != '0) left_d = left_q - CNT_W'(1);
          default:   left_d = left_q;
        endcase
      end
    end
  end

  assign hold_nxt = (left_d != '0);

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else     left_q <= left_d;
  end

  // R6: BUSY neither counts a beat nor releases the hold
  p_busy_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && trans == TR_BUSY && resp != RS_SPLIT && resp != RS_RETRY) |=> $stable(left_q));

  // R7: an IDLE transfer ends a fixed burst immediately
  p_idle_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (ready && trans == TR_IDLE) |=> (left_q == '0));

endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask
  import arb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ready,
  input  logic [1:0]    resp,
  input  logic [IW-1:0] data_owner,
  input  logic [N-1:0]  rel,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  set_vec
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  assign set_vec = (ready && resp == RS_SPLIT) ? (ONE << data_owner) : '0;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q & ~rel) | set_vec;
  end

  // R9: a split response masks the master whose data phase took it
  p_split_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && resp == RS_SPLIT) |=> mask_q[$past(data_owner)]);

  // R10: a release without a same-cycle split clears the bit
  p_release_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (rel != '0) |=> ((mask_q & $past(rel & ~set_vec)) == '0));

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  elig,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // Scan from the highest index down so the lowest eligible one wins.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end

  assign onehot = (elig == '0) ? ONE : (elig & (~elig + ONE));

endmodule

// File: rtl/mst_arbiter.sv
module mst_arbiter
  import arb_pkg::*;
#(
  parameter  int NUM_MST = 16,
  localparam int IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
  localparam int CNT_W   = $clog2(MAX_BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MST-1:0] req,
  input  logic [NUM_MST-1:0] lock_req,
  input  logic [1:0]         trans,
  input  logic [2:0]         burst,
  input  logic [1:0]         resp,
  input  logic               ready,
  input  logic [NUM_MST-1:0] split_rel,
  output logic [NUM_MST-1:0] grant,
  output logic [IDX_W-1:0]   owner,
  output logic [IDX_W-1:0]   data_owner,
  output logic               mst_locked
);

  localparam logic [NUM_MST-1:0] ONE = {{(NUM_MST-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]   left_q;
  logic               burst_hold;
  logic [NUM_MST-1:0] mask_q;
  logic [NUM_MST-1:0] set_vec;
  logic [NUM_MST-1:0] elig;
  logic [IDX_W-1:0]   pick_idx;
  logic [NUM_MST-1:0] pick_oh;
  logic               lock_keep;
  logic               hold;
  logic [IDX_W-1:0]   nxt_owner;
  logic [NUM_MST-1:0] nxt_grant;

  arb_burst_track #(.CNT_W(CNT_W)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .trans    (trans),
    .burst    (burst),
    .resp     (resp),
    .left_q   (left_q),
    .hold_nxt (burst_hold)
  );

  arb_split_mask #(.N(NUM_MST), .IW(IDX_W)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .resp       (resp),
    .data_owner (data_owner),
    .rel        (split_rel),
    .mask_q     (mask_q),
    .set_vec    (set_vec)
  );

  assign elig = req & ~mask_q & ~set_vec;

  arb_prio_pick #(.N(NUM_MST), .IW(IDX_W)) u_pick (
    .elig   (elig),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  assign lock_keep = lock_req[owner] && !set_vec[owner] && !mask_q[owner];
  assign hold      = burst_hold || lock_keep;
  assign nxt_owner = hold ? owner : pick_idx;
  assign nxt_grant = hold ? grant : pick_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner      <= '0;
      grant      <= ONE;
      data_owner <= '0;
      mst_locked <= 1'b0;
    end else if (ready) begin
      owner      <= nxt_owner;
      grant      <= nxt_grant;
      data_owner <= owner;
      mst_locked <= lock_req[nxt_owner];
    end
  end

  // R3: the grant register agrees with the owner register
  p_grant_match_r3: assert property (@(posedge clk) disable iff (rst)
    grant == (ONE << owner));

  // R4: nothing moves while the bus is stalled
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($stable(owner) && $stable(data_owner) && $stable(mst_locked)));

  // R5: the data-phase index trails the owner by one transfer
  p_data_lag_r5: assert property (@(posedge clk) disable iff (rst)
    ready |=> (data_owner == $past(owner)));

  // R6: mid-burst SEQ beats keep the owner
  p_burst_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && trans == TR_SEQ && left_q > CNT_W'(1) &&
     resp != RS_SPLIT && resp != RS_RETRY) |=> $stable(owner));

  // R8: a locked owner is not displaced
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ready && lock_req[owner] && !mask_q[owner] && resp != RS_SPLIT) |=> $stable(owner));

  // R9: a masked master never wins arbitration while another path exists
  p_no_masked_win_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && !hold && elig != '0) |=> !mask_q[owner]);

endmodule

// File: tb/test_mst_arbiter.sv
module test_mst_arbiter;

  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  lock_req = '0;
  logic [1:0]    trans = 2'b00;
  logic [2:0]    burst = 3'b000;
  logic [1:0]    resp = 2'b00;
  logic          ready = 1'b1;
  logic [N-1:0]  split_rel = '0;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner;
  logic [IW-1:0] data_owner;
  logic          mst_locked;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mst_arbiter #(.NUM_MST(N)) i_mst_arbiter (
    .clk(clk), .rst(rst), .req(req), .lock_req(lock_req), .trans(trans),
    .burst(burst), .resp(resp), .ready(ready), .split_rel(split_rel),
    .grant(grant), .owner(owner), .data_owner(data_owner), .mst_locked(mst_locked)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bring master 1 to own both phases, bus idle, everything else quiet.
  task automatic own_by_one();
    req = 4'b0010; lock_req = '0; trans = 2'b00; burst = 3'b000;
    resp = 2'b00; ready = 1'b1; split_rel = '0;
    tick(); tick();
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 owner", int'(owner), 0);
    chk("R1 data_owner", int'(data_owner), 0);
    chk("R1 grant", int'(grant), 1);
    chk("R1 mst_locked", int'(mst_locked), 0);
    rst = 1'b0;

    // R2/R3: every request pattern, expected owner is the lowest set bit
    for (int p = 0; p < 16; p++) begin
      int e;
      e = 0;
      for (int b = N - 1; b >= 0; b--) if (p[b]) e = b;
      req = p[N-1:0];
      tick();
      chk("R2 priority", int'(owner), e);
      chk("R3 grant", int'(grant), 1 << e);
    end

    // R6/R7: every burst code through a complete burst
    for (int b = 0; b < 8; b++) begin
      int len;
      len = (b < 2) ? 0 : (4 << ((b - 2) / 2));
      own_by_one();
      req = 4'b0011; trans = 2'b10; burst = b[2:0];
      tick();
      if (len == 0) begin
        chk("R7 no hold", int'(owner), 0);
      end else begin
        chk("R6 first beat", int'(owner), 1);
        trans = 2'b11;
        for (int k = 1; k < len; k++) begin
          tick();
          chk("R6 beat", int'(owner), (k < len - 1) ? 1 : 0);
        end
      end
      trans = 2'b00;
    end

    // R7: IDLE ends a fixed burst early
    own_by_one();
    req = 4'b0011; trans = 2'b10; burst = 3'b100; tick();
    trans = 2'b11; tick();
    chk("R7 before idle", int'(owner), 1);
    trans = 2'b00; tick();
    chk("R7 idle ends", int'(owner), 0);

    // R6: BUSY does not count
    own_by_one();
    req = 4'b0011; trans = 2'b10; burst = 3'b011; tick();
    trans = 2'b01; tick(); tick();
    chk("R6 busy", int'(owner), 1);
    trans = 2'b11; tick(); tick();
    chk("R6 after busy", int'(owner), 1);
    tick();
    chk("R6 last beat", int'(owner), 0);
    trans = 2'b00;

    // R11: RETRY cancels a burst hold, priority unchanged
    own_by_one();
    resp = 2'b10; tick();
    chk("R11 keeps bus", int'(owner), 1);
    resp = 2'b00;
    req = 4'b0010; trans = 2'b10; burst = 3'b011; tick();
    req = 4'b0011; trans = 2'b11; tick();
    chk("R11 mid burst", int'(owner), 1);
    resp = 2'b10; tick();
    chk("R11 retry ends", int'(owner), 0);
    resp = 2'b00; trans = 2'b00;

    // R4/R5: stall then phase lag
    own_by_one();
    chk("R5 data lag", int'(data_owner), 1);
    req = 4'b0001; ready = 1'b0; tick(); tick();
    chk("R4 owner stall", int'(owner), 1);
    chk("R4 grant stall", int'(grant), 2);
    ready = 1'b1; tick();
    chk("R5 owner moves", int'(owner), 0);
    chk("R5 data follows", int'(data_owner), 1);
    tick();
    chk("R5 data caught", int'(data_owner), 0);

    // R8: locked sequence
    req = 4'b0010; lock_req = 4'b0010; tick();
    chk("R8 owner", int'(owner), 1);
    chk("R8 flag set", int'(mst_locked), 1);
    req = 4'b0011;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 hold", int'(owner), 1);
    end
    lock_req = '0; tick();
    chk("R8 released", int'(owner), 0);
    chk("R8 flag clear", int'(mst_locked), 0);

    // R9/R10: split mask and release
    own_by_one();
    resp = 2'b11; tick();
    chk("R9 split drops", int'(owner), 0);
    resp = 2'b00; tick(); tick();
    chk("R9 masked", int'(owner), 0);
    split_rel = 4'b0010; tick();
    chk("R10 release edge", int'(owner), 0);
    split_rel = '0; tick();
    chk("R10 regranted", int'(owner), 1);
    // R10: set and release in the same cycle, set wins
    tick();
    resp = 2'b11; split_rel = 4'b0010; tick();
    resp = 2'b00; split_rel = '0; tick(); tick();
    chk("R10 set wins", int'(owner), 0);
    split_rel = 4'b0010; tick();
    split_rel = '0; tick();
    chk("R10 final", int'(owner), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule